// File: doc/BRIEF.md
# PCI Single-Phase Target Controller

This block is the bus-facing part of a target-only 32-bit PCI device running at 33 MHz. It watches each address phase and claims three kinds of cycle: type 0 configuration cycles aimed at one of its two functions, I/O cycles that fall inside its I/O window, and memory cycles that fall inside its memory window. Each claimed cycle becomes exactly one access on a simple internal register bus. That bus carries a space code, a register address, byte enables, write data, a one-cycle read or write strobe, and read data that the back-end returns combinationally during the strobe.

The controller drives DEVSEL#, TRDY# and STOP#. It checks address and write-data parity and drives PAR for read data. It never lets a burst go on: every transfer ends as a disconnect-with-data. While a configuration load is in progress, it answers every claimed access with Retry. Registers that are one byte wide sit one per DWORD in memory space, and a two-bit lane selector names the byte enable that such an access must carry. In I/O space, the single byte enable must agree with the low address bits. An access that fails either test still ends normally on the bus but leaves the registers untouched.

Top module: `pci_target_ctl`

## Requirements
- R1: A configuration cycle (command 1011 write, 1010 read) is claimed only when IDSEL is high in the address phase, AD[1:0] is 00, and the function number AD[10:8] is 0. Function 1 is also claimed, but only while `dualFunc` is high. Any other configuration cycle never drives DEVSEL# low.
- R2: Take edge k as the rising edge where FRAME# is first sampled low. On a hit, DEVSEL# goes low at edge k+2 (medium decode).
- R3: A completed transfer drives TRDY# and STOP# low together for exactly one clock, starting one edge after the register strobe. DEVSEL#, TRDY# and STOP# are released at the next edge once FRAME# is high.
- R4: If `cfgLoadBusy` is high at edge k+2, the cycle is claimed with Retry. STOP# goes low and TRDY# stays high. No strobe is issued, and STOP# is released once FRAME# is sampled high.
- R5: A memory cycle (command 0111 write, 0110 read) inside the window given by `memBase` puts register index AD[MEM_AW-1:2] on `regAddr` and space code 2 on `regSpace`. It strobes only if the byte enables are exactly the one-hot lane named by `laneSel`: 00 means bits 7:0 (BE0), up through 11 meaning bits 31:24 (BE3).
- R6: An I/O cycle (command 0011 write, 0010 read) inside the window given by `ioBase` puts AD[IO_AW-1:0] on `regAddr` and space code 1 on `regSpace`. It strobes only if exactly one byte enable is asserted and its index equals AD[1:0].
- R7: A claimed cycle whose byte enables fail R5 or R6 still completes with TRDY# and STOP#, but issues no strobe. A read of this kind returns zero.
- R8: A parity error in the address phase drives SERR# low for one clock, from edge k+1. A cycle that still decodes as a hit completes normally.
- R9: Every command other than the six listed above is never claimed. This covers special cycles (0001), dual-address cycles (1101) and reserved codes such as 0100.
- R10: A configuration access strobes with any byte-enable pattern, zero included. `regBe` equals the asserted enables, and `regAddr` is {AD[8], AD[7:2]} with space code 0.
- R11: After a completed read, PAR is driven for one clock starting one edge after the data phase ends. Its value makes the parity over the returned AD, C/BE# and PAR even.
- R12: After a completed write, the PAR sampled one edge after the data phase ends is checked against the write data and byte enables. On a mismatch, PERR# goes low for one clock.
- R13: Each completed, qualified data phase gives exactly one strobe, one clock long, issued one edge before TRDY#. Reads use `regRd` and writes use `regWr`. No read strobe is issued before the master has asserted IRDY#.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adIn | input | 32 | AD bus as seen from the bus |
| adOut | output | 32 | Read data driven onto AD |
| adOe | output | 1 | Output enable for `adOut` |
| cbeN | input | 4 | Command / byte enables, active low |
| parIn | input | 1 | PAR as seen from the bus |
| parOut | output | 1 | PAR driven for read data |
| parOe | output | 1 | Output enable for `parOut` |
| frameN | input | 1 | FRAME#, active low |
| irdyN | input | 1 | IRDY#, active low |
| idsel | input | 1 | Configuration select |
| devselN | output | 1 | DEVSEL#, active low |
| trdyN | output | 1 | TRDY#, active low |
| stopN | output | 1 | STOP#, active low |
| ctrlOe | output | 1 | Output enable for DEVSEL#, TRDY# and STOP# |
| serrN | output | 1 | Address parity error flag, active low |
| perrN | output | 1 | Write data parity error flag, active low |
| dualFunc | input | 1 | High: function 1 exists |
| cfgLoadBusy | input | 1 | High: configuration load running, retry all |
| laneSel | input | 2 | Active byte lane for memory byte registers |
| ioBase | input | 32-IO_AW | I/O window base, upper address bits |
| memBase | input | 32-MEM_AW | Memory window base, upper address bits |
| regAddr | output | MEM_AW-2 | Internal register address |
| regSpace | output | 2 | 0 configuration, 1 I/O, 2 memory |
| regBe | output | 4 | Internal byte enables, active high |
| regWdata | output | 32 | Internal write data |
| regRd | output | 1 | Internal read strobe |
| regWr | output | 1 | Internal write strobe |
| regRdata | input | 32 | Internal read data, valid during `regRd` |

## Verification
When the master drives IRDY# in the clock after the address, each result has a fixed edge. SERR# is due at k+1. DEVSEL# and the strobe with its address, space and enables are due at k+2. TRDY#, STOP# and read data are due at k+3, read PAR at k+4, and PERR# at k+5. The bench drives a whole cycle from one task and records every output on the falling edge after each of the six edges that follow the address. Each check then compares one recorded slot with its expected value, and strobes are counted on every rising edge so that a missing strobe or an extra one shows up.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    SPACE_CFG = 2'd0,
    SPACE_IO  = 2'd1,
    SPACE_MEM = 2'd2
  } space_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capAddr;     // latch address phase
    logic chkAddrPar;  // compare address parity
    logic capData;     // latch byte enables / write data
    logic capRead;     // latch read data and drive AD
    logic endPhase;    // data phase finished, release AD
    logic chkDataPar;  // compare write data parity
  } ctl_strb_t;

  function automatic logic evenPar(logic [31:0] d, logic [3:0] c);
    return ^{d, c};
  endfunction

endpackage

// File: rtl/pci_tgt_dp.sv
module pci_tgt_dp
  import pci_tgt_pkg::*;
#(
  parameter int IO_AW  = 4,
  parameter int MEM_AW = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         adIn,
  input  logic [3:0]          cbeN,
  input  logic                parIn,
  input  logic                idsel,
  input  logic                dualFunc,
  input  logic [1:0]          laneSel,
  input  logic [31:IO_AW]     ioBase,
  input  logic [31:MEM_AW]    memBase,
  input  ctl_strb_t           ctl,
  output logic                hit,
  output logic                isWrite,
  output logic                qualNow,
  output logic [MEM_AW-3:0]   regAddr,
  output logic [1:0]          regSpace,
  output logic [3:0]          regBe,
  output logic [31:0]         regWdata,
  input  logic [31:0]         regRdata,
  output logic [31:0]         adOut,
  output logic                adOe,
  output logic                parOut,
  output logic                parOe,
  output logic                serrN,
  output logic                perrN
);

  localparam int REG_AW = MEM_AW - 2;

  logic [31:0] addrQ;
  logic [3:0]  cmdQ;
  logic        idselQ;
  logic [3:0]  beQ;
  logic [31:0] wdataQ;
  logic        qualQ;
  logic        pendPerr;

  logic        isCfg, isIo, isMem;
  logic        cfgHit, ioHit, memHit;
  logic [2:0]  funcNum;
  space_e      spaceC;
  logic [REG_AW-1:0] regAddrC;
  logic [3:0]  liveBe;

  assign funcNum = addrQ[10:8];
  assign liveBe  = ~cbeN;
  assign isCfg   = (cmdQ == CMD_CFG_RD) || (cmdQ == CMD_CFG_WR);
  assign isIo    = (cmdQ == CMD_IO_RD)  || (cmdQ == CMD_IO_WR);
  assign isMem   = (cmdQ == CMD_MEM_RD) || (cmdQ == CMD_MEM_WR);

  assign cfgHit = isCfg && idselQ && (addrQ[1:0] == 2'b00) &&
                  ((funcNum == 3'd0) || ((funcNum == 3'd1) && dualFunc));
  assign ioHit  = isIo  && (addrQ[31:IO_AW]  == ioBase);
  assign memHit = isMem && (addrQ[31:MEM_AW] == memBase);
  assign hit     = cfgHit || ioHit || memHit;
  assign isWrite = cmdQ[0];

  always_comb begin
    if (isCfg)     spaceC = SPACE_CFG;
    else if (isIo) spaceC = SPACE_IO;
    else           spaceC = SPACE_MEM;
  end

  // byte-lane qualification against the live byte enables
  always_comb begin
    unique case (spaceC)
      SPACE_CFG: qualNow = 1'b1;
      SPACE_IO:  qualNow = (liveBe == (4'b0001 << addrQ[1:0]));
      default:   qualNow = (liveBe == (4'b0001 << laneSel));
    endcase
  end

  always_comb begin
    regAddrC = '0;
    unique case (spaceC)
      SPACE_CFG: regAddrC[6:0] = {addrQ[8], addrQ[7:2]};
      SPACE_IO:  regAddrC[IO_AW-1:0] = addrQ[IO_AW-1:0];
      default:   regAddrC = addrQ[MEM_AW-1:2];
    endcase
  end

  assign regAddr  = regAddrC;
  assign regSpace = spaceC;
  assign regBe    = beQ;
  assign regWdata = wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      cmdQ     <= '0;
      idselQ   <= 1'b0;
      beQ      <= '0;
      wdataQ   <= '0;
      qualQ    <= 1'b0;
      pendPerr <= 1'b0;
      adOut    <= '0;
      adOe     <= 1'b0;
      parOut   <= 1'b0;
      parOe    <= 1'b0;
      serrN    <= 1'b1;
      perrN    <= 1'b1;
    end else begin
      serrN <= 1'b1;
      perrN <= 1'b1;
      if (ctl.capAddr) begin
        addrQ  <= adIn;
        cmdQ   <= cbeN;
        idselQ <= idsel;
      end
      if (ctl.chkAddrPar && (evenPar(addrQ, cmdQ) != parIn)) serrN <= 1'b0;
      if (ctl.capData) begin
        beQ    <= liveBe;
        wdataQ <= adIn;
        qualQ  <= qualNow;
      end
      if (ctl.capRead) begin
        adOut <= qualQ ? regRdata : '0;
        adOe  <= 1'b1;
      end
      if (ctl.endPhase) begin
        adOe     <= 1'b0;
        parOe    <= !isWrite;
        parOut   <= evenPar(adOut, ~beQ);
        pendPerr <= isWrite;
      end
      if (ctl.chkDataPar) begin
        parOe    <= 1'b0;
        pendPerr <= 1'b0;
        if (pendPerr && (evenPar(wdataQ, ~beQ) != parIn)) perrN <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      cfgLoadBusy,
  input  logic      hit,
  input  logic      isWrite,
  input  logic      qualNow,
  output ctl_strb_t ctl,
  output logic      devselN,
  output logic      trdyN,
  output logic      stopN,
  output logic      ctrlOe,
  output logic      regRd,
  output logic      regWr
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_CLM, ST_XFER, ST_STRB, ST_DONE, ST_TURN, ST_WAIT
  } state_e;

  state_e st;
  logic   okQ;   // high: data moved, low: retry

  always_comb begin
    ctl = '0;
    unique case (st)
      ST_IDLE: ctl.capAddr    = !frameN;
      ST_DEC:  ctl.chkAddrPar = 1'b1;
      ST_CLM:  ctl.capData    = !irdyN && !cfgLoadBusy;
      ST_XFER: ctl.capData    = !irdyN;
      ST_STRB: ctl.capRead    = !isWrite;
      ST_DONE: ctl.endPhase   = frameN && okQ;
      ST_TURN: ctl.chkDataPar = 1'b1;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      okQ     <= 1'b0;
      devselN <= 1'b1;
      trdyN   <= 1'b1;
      stopN   <= 1'b1;
      ctrlOe  <= 1'b0;
      regRd   <= 1'b0;
      regWr   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (!frameN) st <= ST_DEC;
        ST_DEC:  st <= hit ? ST_CLM : ST_WAIT;
        ST_CLM: begin
          devselN <= 1'b0;
          ctrlOe  <= 1'b1;
          if (cfgLoadBusy) begin
            stopN <= 1'b0;
            okQ   <= 1'b0;
            st    <= ST_DONE;
          end else if (!irdyN) begin
            regRd <= qualNow && !isWrite;
            regWr <= qualNow && isWrite;
            st    <= ST_STRB;
          end else begin
            st <= ST_XFER;
          end
        end
        ST_XFER: if (!irdyN) begin
          regRd <= qualNow && !isWrite;
          regWr <= qualNow && isWrite;
          st    <= ST_STRB;
        end
        ST_STRB: begin
          regRd <= 1'b0;
          regWr <= 1'b0;
          trdyN <= 1'b0;
          stopN <= 1'b0;
          okQ   <= 1'b1;
          st    <= ST_DONE;
        end
        ST_DONE: if (frameN) begin
          devselN <= 1'b1;
          trdyN   <= 1'b1;
          stopN   <= 1'b1;
          st      <= ST_TURN;
        end
        ST_TURN: begin
          ctrlOe <= 1'b0;
          st     <= ST_IDLE;
        end
        ST_WAIT: if (frameN && irdyN) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_target_ctl.sv
module pci_target_ctl
  import pci_tgt_pkg::*;
#(
  parameter int IO_AW  = 4,
  parameter int MEM_AW = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         adIn,
  output logic [31:0]         adOut,
  output logic                adOe,
  input  logic [3:0]          cbeN,
  input  logic                parIn,
  output logic                parOut,
  output logic                parOe,
  input  logic                frameN,
  input  logic                irdyN,
  input  logic                idsel,
  output logic                devselN,
  output logic                trdyN,
  output logic                stopN,
  output logic                ctrlOe,
  output logic                serrN,
  output logic                perrN,
  input  logic                dualFunc,
  input  logic                cfgLoadBusy,
  input  logic [1:0]          laneSel,
  input  logic [31:IO_AW]     ioBase,
  input  logic [31:MEM_AW]    memBase,
  output logic [MEM_AW-3:0]   regAddr,
  output logic [1:0]          regSpace,
  output logic [3:0]          regBe,
  output logic [31:0]         regWdata,
  output logic                regRd,
  output logic                regWr,
  input  logic [31:0]         regRdata
);

  ctl_strb_t ctl;
  logic      hit, isWrite, qualNow;

  pci_tgt_ctrl u_ctrl (
    .clk, .rstN, .frameN, .irdyN, .cfgLoadBusy,
    .hit, .isWrite, .qualNow, .ctl,
    .devselN, .trdyN, .stopN, .ctrlOe, .regRd, .regWr
  );

  pci_tgt_dp #(.IO_AW(IO_AW), .MEM_AW(MEM_AW)) u_dp (
    .clk, .rstN, .adIn, .cbeN, .parIn, .idsel, .dualFunc, .laneSel,
    .ioBase, .memBase, .ctl, .hit, .isWrite, .qualNow,
    .regAddr, .regSpace, .regBe, .regWdata, .regRdata,
    .adOut, .adOe, .parOut, .parOe, .serrN, .perrN
  );

endmodule

// File: rtl/pci_tgt_chk.sv
module pci_tgt_chk (
  input logic        clk,
  input logic        rstN,
  input logic        frameN,
  input logic        cfgLoadBusy,
  input logic        devselN,
  input logic        trdyN,
  input logic        stopN,
  input logic        serrN,
  input logic        regRd,
  input logic        regWr,
  input logic [1:0]  regSpace,
  input logic [3:0]  regBe,
  input logic [1:0]  laneSel,
  input logic [31:0] adOut,
  input logic        adOe,
  input logic [3:0]  cbeN,
  input logic        parOut,
  input logic        parOe
);

  // R3
  disconnect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !stopN);

  // R3
  trdy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |=> trdyN);

  // R2
  medium_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> !$past(frameN, 3));

  // R4
  retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(devselN) && $past(cfgLoadBusy)) |-> (!stopN && trdyN));

  // R13
  strobe_then_trdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd || regWr) |=> !trdyN);

  // R5
  mem_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSpace == 2'd2) |-> (regBe == (4'b0001 << laneSel)));

  // R11
  read_par_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parOe) |-> (parOut == ^{$past(adOut), $past(cbeN)}));

  // R8
  serr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !serrN |=> serrN);

  // R3
  ad_claimed_chk: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !devselN);

endmodule

bind pci_target_ctl pci_tgt_chk u_chk (
  .clk, .rstN, .frameN, .cfgLoadBusy, .devselN, .trdyN, .stopN, .serrN,
  .regRd, .regWr, .regSpace, .regBe, .laneSel, .adOut, .adOe, .cbeN,
  .parOut, .parOe
);

// File: tb/pci_target_ctl_tb.sv
module pci_target_ctl_tb;

  localparam int IO_AW  = 4;
  localparam int MEM_AW = 12;
  localparam logic [31:0] IO_WIN  = 32'h0000_1F30;
  localparam logic [31:0] MEM_WIN = 32'hFEB0_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] adIn = '0;
  logic [31:0] adOut;
  logic adOe;
  logic [3:0] cbeN = 4'hF;
  logic parIn = 1'b0;
  logic parOut, parOe;
  logic frameN = 1'b1, irdyN = 1'b1, idsel = 1'b0;
  logic devselN, trdyN, stopN, ctrlOe, serrN, perrN;
  logic dualFunc = 1'b1, cfgLoadBusy = 1'b0;
  logic [1:0] laneSel = 2'd0;
  logic [MEM_AW-3:0] regAddr;
  logic [1:0] regSpace;
  logic [3:0] regBe;
  logic [31:0] regWdata, regRdata;
  logic regRd, regWr;

  always #10 clk = ~clk;

  // back-end model: data encodes space and address
  assign regRdata = {8'hC3, 6'b0, regSpace, 6'b0, regAddr};

  pci_target_ctl #(.IO_AW(IO_AW), .MEM_AW(MEM_AW)) u_dut (
    .clk, .rstN, .adIn, .adOut, .adOe, .cbeN, .parIn, .parOut, .parOe,
    .frameN, .irdyN, .idsel, .devselN, .trdyN, .stopN, .ctrlOe, .serrN,
    .perrN, .dualFunc, .cfgLoadBusy, .laneSel,
    .ioBase(IO_WIN[31:IO_AW]), .memBase(MEM_WIN[31:MEM_AW]),
    .regAddr, .regSpace, .regBe, .regWdata, .regRd, .regWr, .regRdata
  );

  int checks = 0;
  int fails = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (regRd) rdCnt++;
    if (regWr) wrCnt++;
  end

  logic        oDev[1:6], oTrdy[1:6], oStop[1:6], oSerr[1:6], oPerr[1:6];
  logic        oParOe[1:6], oPar[1:6], oAdOe[1:6];
  logic [31:0] oAd[1:6];
  logic [31:0] sAddr, sWdata;
  logic [1:0]  sSpace;
  logic [3:0]  sBe;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one single-phase transaction, master asserts IRDY# right after address
  task automatic busCycle(logic [3:0] cmd, logic [31:0] addr, logic [3:0] be,
                          logic [31:0] wdata, logic idselV, bit badA, bit badD);
    bit ended = 0;
    repeat (2) @(negedge clk);
    rdCnt = 0; wrCnt = 0;
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = idselV;
    @(negedge clk);
    frameN = 1'b1; irdyN = 1'b0; adIn = wdata; cbeN = ~be; idsel = 1'b0;
    parIn = (^{addr, cmd}) ^ badA;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      oDev[j] = devselN; oTrdy[j] = trdyN; oStop[j] = stopN;
      oSerr[j] = serrN; oPerr[j] = perrN; oParOe[j] = parOe;
      oPar[j] = parOut; oAdOe[j] = adOe; oAd[j] = adOut;
      if (j == 2) begin
        sAddr = 32'(regAddr); sSpace = regSpace; sBe = regBe; sWdata = regWdata;
      end
      if (j == 1) parIn = 1'b0;
      if (ended) begin
        irdyN = 1'b1; cbeN = 4'hF;
        parIn = (^{wdata, ~be}) ^ badD;
        ended = 0;
      end
      if (!stopN && irdyN == 1'b0) ended = 1;
      if (j == 5) irdyN = 1'b1;
    end
    parIn = 1'b0;
  endtask

  task automatic noClaim(string tag);
    for (int j = 1; j <= 6; j++) chk(tag, 32'(oDev[j]), 32'd1);
    chk(tag, 32'(rdCnt + wrCnt), 32'd0);
  endtask

  task automatic tReset;
    chk("R3 reset devsel", 32'(devselN), 32'd1);
    chk("R3 reset trdy", 32'(trdyN), 32'd1);
    chk("R3 reset stop", 32'(stopN), 32'd1);
    chk("R13 reset strobes", {30'd0, regRd, regWr}, 32'd0);
    chk("R8 reset serr", 32'(serrN), 32'd1);
    chk("R11 reset oe", {29'd0, adOe, parOe, ctrlOe}, 32'd0);
  endtask

  task automatic tCfgWrite;
    busCycle(4'b1011, 32'h0000_0014, 4'b0101, 32'h1234_5678, 1'b1, 0, 0);
    chk("R2 devsel not before k+2", 32'(oDev[1]), 32'd1);
    chk("R2 devsel at k+2", 32'(oDev[2]), 32'd0);
    chk("R13 one write strobe", 32'(wrCnt), 32'd1);
    chk("R10 cfg addr", sAddr, 32'd5);
    chk("R10 cfg space", 32'(sSpace), 32'd0);
    chk("R10 cfg be", 32'(sBe), 32'b0101);
    chk("R13 wdata", sWdata, 32'h1234_5678);
    chk("R3 trdy at k+3", 32'(oTrdy[3]), 32'd0);
    chk("R3 stop at k+3", 32'(oStop[3]), 32'd0);
    chk("R3 release trdy", 32'(oTrdy[4]), 32'd1);
    chk("R3 release devsel", 32'(oDev[4]), 32'd1);
    chk("R12 no perr good parity", 32'(oPerr[5]), 32'd1);
  endtask

  task automatic tCfgZeroBe;
    busCycle(4'b1011, 32'h0000_0008, 4'b0000, 32'h0, 1'b1, 0, 0);
    chk("R10 zero-be strobe", 32'(wrCnt), 32'd1);
    chk("R10 zero-be value", 32'(sBe), 32'd0);
  endtask

  task automatic tCfgReadF1;
    logic [31:0] exp;
    dualFunc = 1'b1;
    busCycle(4'b1010, 32'h0000_0124, 4'b1111, 32'h0, 1'b1, 0, 0);
    exp = {8'hC3, 6'b0, 2'd0, 6'b0, 10'd73};
    chk("R1 f1 dual claimed", 32'(oDev[2]), 32'd0);
    chk("R13 one read strobe", 32'(rdCnt), 32'd1);
    chk("R13 read data", oAd[3], exp);
    chk("R13 ad driven", 32'(oAdOe[3]), 32'd1);
    chk("R11 par oe", 32'(oParOe[4]), 32'd1);
    chk("R11 par value", 32'(oPar[4]), 32'(^{exp, 4'b0000}));
    chk("R11 par released", 32'(oParOe[5]), 32'd0);
  endtask

  task automatic tCfgUnclaimed;
    dualFunc = 1'b0;
    busCycle(4'b1010, 32'h0000_0124, 4'b1111, 32'h0, 1'b1, 0, 0);
    noClaim("R1 f1 single mode");
    dualFunc = 1'b1;
    busCycle(4'b1011, 32'h0000_0014, 4'b1111, 32'h0, 1'b0, 0, 0);
    noClaim("R1 idsel low");
  endtask

  task automatic tMem;
    laneSel = 2'd2;
    busCycle(4'b0111, MEM_WIN | 32'h94, 4'b0100, 32'hAB00_0000, 1'b0, 0, 0);
    chk("R5 mem lane hit", 32'(wrCnt), 32'd1);
    chk("R5 mem addr", sAddr, 32'd37);
    chk("R5 mem space", 32'(sSpace), 32'd2);
    busCycle(4'b0111, MEM_WIN | 32'h94, 4'b0001, 32'h0, 1'b0, 0, 0);
    chk("R7 mem mismatch completes", 32'(oTrdy[3]), 32'd0);
    chk("R7 mem mismatch no strobe", 32'(wrCnt), 32'd0);
    laneSel = 2'd3;
    busCycle(4'b0110, MEM_WIN | 32'h320, 4'b1000, 32'h0, 1'b0, 0, 0);
    chk("R5 mem read strobe", 32'(rdCnt), 32'd1);
    chk("R5 mem read data", oAd[3], {8'hC3, 6'b0, 2'd2, 6'b0, 10'd200});
  endtask

  task automatic tIo;
    busCycle(4'b0011, IO_WIN | 32'h2, 4'b0100, 32'h0055_0000, 1'b0, 0, 0);
    chk("R6 io hit", 32'(wrCnt), 32'd1);
    chk("R6 io addr", sAddr, 32'd2);
    chk("R6 io space", 32'(sSpace), 32'd1);
    busCycle(4'b0010, IO_WIN, 4'b0011, 32'h0, 1'b0, 0, 0);
    chk("R7 io mismatch completes", 32'(oTrdy[3]), 32'd0);
    chk("R7 io mismatch no strobe", 32'(rdCnt), 32'd0);
    chk("R7 io mismatch zero data", oAd[3], 32'd0);
    busCycle(4'b0011, 32'h0000_1F40, 4'b0001, 32'h0, 1'b0, 0, 0);
    noClaim("R6 io outside window");
  endtask

  task automatic tRetry;
    cfgLoadBusy = 1'b1;
    busCycle(4'b1011, 32'h0000_0014, 4'b1111, 32'h0, 1'b1, 0, 0);
    cfgLoadBusy = 1'b0;
    chk("R4 retry devsel", 32'(oDev[2]), 32'd0);
    chk("R4 retry stop", 32'(oStop[2]), 32'd0);
    chk("R4 retry no trdy", 32'(oTrdy[2]), 32'd1);
    chk("R4 retry no trdy late", 32'(oTrdy[3]), 32'd1);
    chk("R4 retry stop released", 32'(oStop[3]), 32'd1);
    chk("R4 retry no strobe", 32'(rdCnt + wrCnt), 32'd0);
  endtask

  task automatic tAddrParity;
    busCycle(4'b1011, 32'h0000_0014, 4'b1111, 32'h0, 1'b1, 1, 0);
    chk("R8 serr at k+1", 32'(oSerr[1]), 32'd0);
    chk("R8 serr one clock", 32'(oSerr[2]), 32'd1);
    chk("R8 still completes", 32'(wrCnt), 32'd1);
    busCycle(4'b1011, 32'h0000_0014, 4'b1111, 32'h0, 1'b1, 0, 0);
    chk("R8 no serr good parity", 32'(oSerr[1]), 32'd1);
  endtask

  task automatic tIgnored;
    busCycle(4'b0001, MEM_WIN, 4'b1111, 32'h0, 1'b0, 0, 0);
    noClaim("R9 special cycle");
    busCycle(4'b1101, MEM_WIN, 4'b1111, 32'h0, 1'b0, 0, 0);
    noClaim("R9 dual address");
    busCycle(4'b0100, MEM_WIN, 4'b1111, 32'h0, 1'b0, 0, 0);
    noClaim("R9 reserved");
  endtask

  task automatic tDataParity;
    busCycle(4'b1011, 32'h0000_0014, 4'b1111, 32'hCAFE_0001, 1'b1, 0, 1);
    chk("R12 perr at k+5", 32'(oPerr[5]), 32'd0);
    chk("R12 perr one clock", 32'(oPerr[6]), 32'd1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCfgWrite();
    tCfgZeroBe();
    tCfgReadF1();
    tCfgUnclaimed();
    tMem();
    tIo();
    tRetry();
    tAddrParity();
    tIgnored();
    tDataParity();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule